// File: doc/BRIEF.md
# Page-Write Non-Volatile Commit Controller

This block sits between a two-wire serial slave front end and the array of a small byte-wide non-volatile store of 2048 bytes, organised as 128 pages of 16 bytes. While a write sequence is on the bus, the front end hands over one strobe per received data byte together with the full 11-bit byte address. The block keeps the page of the first byte, steps the in-page offset for each further byte, and holds the bytes in a 16-entry page buffer with a per-byte written flag.

When the stop condition arrives and the buffer holds at least one byte, the block raises a busy flag and starts one self-timed programming period. Its length is a parameter in clock cycles, so a real 6 to 12 ms window can be shortened for simulation. When the period ends, the buffered bytes are handed to the memory model as a burst of commit requests, one per written byte. Busy then drops and the block returns to standby. While busy is high, the front end must stay deaf to the bus, and the block itself ignores every input from it. Bytes aimed at volatile locations are never buffered. The access-control byte at the top address minus one is always volatile. The top byte is volatile only while the volatile-only selector is high. A sequence that touched only volatile bytes therefore goes straight back to standby on stop.

Top module: `pwc_nv_commit_ctrl`

## Requirements
- R1: After reset, busy_o and commit_valid_o are 0.
- R2: The first data byte after a start, a stop or reset goes to wr_addr_i. Each following byte goes to the next offset (address bits 3:0) of the same page (bits 10:4). After offset 15 the next byte goes to offset 0 of that same page, and the page never changes.
- R3: A byte written to an offset already filled in the same sequence replaces the earlier byte, so only the last one is committed.
- R4: A stop pulse that finds at least one buffered byte raises busy_o in the cycle after the stop edge. busy_o then stays high for exactly CYCLE_CLKS + 16 cycles.
- R5: Commits start right after the CYCLE_CLKS programming cycles, during a 16-cycle burst. In burst cycle i, commit_valid_o is high if and only if offset i was written. When it is high, commit_addr_o is {page, i} and commit_data_o is the byte for offset i. Commits therefore come in ascending offset order.
- R6: Address 2046 is always volatile. Address 2047 is volatile while vol_only_i is 1 at its strobe. Volatile bytes are not buffered. A sequence made only of volatile bytes ends on stop with busy_o staying 0 and no commit.
- R7: A start pulse before the stop discards all buffered bytes, so a following stop launches nothing.
- R8: While busy_o is 1, start_i, stop_i and wr_stb_i have no effect. Nothing is added to or removed from the page being committed, and no byte is buffered for later.
- R9: A stop with an empty buffer leaves busy_o at 0 and produces no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: start condition seen on the bus |
| stop_i | input | 1 | One-cycle pulse: stop condition seen on the bus |
| wr_stb_i | input | 1 | One-cycle pulse: a write data byte was received |
| wr_addr_i | input | 11 | Byte address, used for the first byte of a sequence |
| wr_data_i | input | 8 | Received data byte |
| vol_only_i | input | 1 | 1: the top address is a volatile-only location |
| busy_o | output | 1 | Programming period or commit burst in progress |
| commit_valid_o | output | 1 | A commit request is presented this cycle |
| commit_addr_o | output | 11 | Address of the committed byte |
| commit_data_o | output | 8 | Value of the committed byte |

## Verification
The hardest case to reach from the ports is a commit burst whose bytes came from a wrapped sequence. There, later bytes have overwritten earlier ones at the same offsets, and the burst must carry only the survivors in offset order. The bench sweeps every start offset with lengths from 1 to 18 bytes, on a low page, a middle page and the top page. On the top page the volatile-only selector alternates, so the wrap, the overwrite and the volatile skip all show up in the same sweep. A separate run drives strobes, starts and stops into the window where busy is high. Afterwards it checks both the committed burst and that a bare stop launches nothing, which proves that nothing leaked into the buffer.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    localparam int PW_ADDR_W = 11;
    localparam int PW_OFF_W  = 4;
    localparam int PW_DATA_W = 8;
    localparam int PW_PAGE_W = PW_ADDR_W - PW_OFF_W;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_PROG   = 2'd1,
        ST_COMMIT = 2'd2
    } pw_state_t;

    typedef struct packed {
        pw_state_t              st;
        logic                   based;
        logic [PW_PAGE_W-1:0]   page;
        logic [PW_OFF_W-1:0]    off;
        logic [PW_OFF_W-1:0]    idx;
    } pw_ctl_t;
endpackage

// File: rtl/pwc_cycle_timer.sv
module pwc_cycle_timer #(
    parameter int CYCLE_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int CW = $clog2(CYCLE_CLKS + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(CYCLE_CLKS);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == CNT_ONE);
endmodule

// File: rtl/pwc_page_buffer.sv
module pwc_page_buffer #(
    parameter int OFF_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [OFF_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [OFF_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              any_o
);
    localparam int DEPTH = 1 << OFF_W;

    logic [DATA_W-1:0] slot   [DEPTH];
    logic [DEPTH-1:0]  filled;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] byte_q;
        logic              hit_q;
        logic              sel;

        assign sel = we_i && (waddr_i == OFF_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
                hit_q  <= 1'b0;
            end else begin
                if (sel) begin
                    byte_q <= wdata_i;
                end
                if (clr_i) begin
                    hit_q <= 1'b0;
                end else if (sel) begin
                    hit_q <= 1'b1;
                end
            end
        end

        assign slot[g]   = byte_q;
        assign filled[g] = hit_q;
    end

    assign rdata_o  = slot[raddr_i];
    assign rvalid_o = filled[raddr_i];
    assign any_o    = |filled;
endmodule

// File: rtl/pwc_nv_commit_ctrl.sv
module pwc_nv_commit_ctrl
    import pwc_pkg::*;
#(
    parameter int CYCLE_CLKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 stop_i,
    input  logic                 wr_stb_i,
    input  logic [PW_ADDR_W-1:0] wr_addr_i,
    input  logic [PW_DATA_W-1:0] wr_data_i,
    input  logic                 vol_only_i,
    output logic                 busy_o,
    output logic                 commit_valid_o,
    output logic [PW_ADDR_W-1:0] commit_addr_o,
    output logic [PW_DATA_W-1:0] commit_data_o
);
    localparam logic [PW_ADDR_W-1:0] TOP_ADDR  = '1;
    localparam logic [PW_ADDR_W-1:0] CTRL_ADDR = TOP_ADDR - PW_ADDR_W'(1);
    localparam logic [PW_OFF_W-1:0]  OFF_ONE   = PW_OFF_W'(1);
    localparam logic [PW_OFF_W-1:0]  OFF_LAST  = '1;

    pw_ctl_t q, d;

    logic                 timer_load, timer_done;
    logic                 buf_clr, buf_we, buf_valid, buf_any;
    logic [PW_DATA_W-1:0] buf_rdata;
    logic [PW_ADDR_W-1:0] eff_addr;
    logic                 eff_volatile;

    always_comb begin
        eff_addr     = q.based ? {q.page, q.off + OFF_ONE} : wr_addr_i;
        eff_volatile = (eff_addr == CTRL_ADDR) ||
                       ((eff_addr == TOP_ADDR) && vol_only_i);
    end

    always_comb begin
        d          = q;
        timer_load = 1'b0;
        buf_clr    = 1'b0;
        buf_we     = 1'b0;
        unique case (q.st)
            ST_OPEN: begin
                if (start_i) begin
                    buf_clr = 1'b1;
                    d.based = 1'b0;
                end else if (stop_i) begin
                    d.based = 1'b0;
                    if (buf_any) begin
                        d.st       = ST_PROG;
                        timer_load = 1'b1;
                    end
                end else if (wr_stb_i) begin
                    d.based = 1'b1;
                    d.page  = eff_addr[PW_ADDR_W-1:PW_OFF_W];
                    d.off   = eff_addr[PW_OFF_W-1:0];
                    buf_we  = !eff_volatile;
                end
            end
            ST_PROG: begin
                if (timer_done) begin
                    d.st  = ST_COMMIT;
                    d.idx = '0;
                end
            end
            ST_COMMIT: begin
                d.idx = q.idx + OFF_ONE;
                if (q.idx == OFF_LAST) begin
                    d.st    = ST_OPEN;
                    buf_clr = 1'b1;
                end
            end
            default: d.st = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_OPEN, based: 1'b0, page: '0, off: '0, idx: '0};
        end else begin
            q <= d;
        end
    end

    pwc_cycle_timer #(
        .CYCLE_CLKS(CYCLE_CLKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (timer_load),
        .done_o (timer_done)
    );

    pwc_page_buffer #(
        .OFF_W  (PW_OFF_W),
        .DATA_W (PW_DATA_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (buf_clr),
        .we_i     (buf_we),
        .waddr_i  (eff_addr[PW_OFF_W-1:0]),
        .wdata_i  (wr_data_i),
        .raddr_i  (q.idx),
        .rdata_o  (buf_rdata),
        .rvalid_o (buf_valid),
        .any_o    (buf_any)
    );

    assign busy_o         = (q.st != ST_OPEN);
    assign commit_valid_o = (q.st == ST_COMMIT) && buf_valid;
    assign commit_addr_o  = {q.page, q.idx};
    assign commit_data_o  = buf_rdata;
endmodule

// File: rtl/pwc_nv_commit_chk.sv
module pwc_nv_commit_chk #(
    parameter int CYCLE_CLKS = 8,
    parameter int ADDR_W     = 11,
    parameter int OFF_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_i,
    input logic              busy_o,
    input logic              commit_valid_o,
    input logic [ADDR_W-1:0] commit_addr_o
);
    localparam int BUSY_LEN = CYCLE_CLKS + (1 << OFF_W);

    logic [31:0] busy_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run_q <= '0;
        end else if (busy_o) begin
            busy_run_q <= busy_run_q + 32'd1;
        end else begin
            busy_run_q <= '0;
        end
    end

    // R4
    stop_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    // R4
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_run_q == 32'(BUSY_LEN)));

    // R5
    commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid_o |-> busy_o);

    // R2
    same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid_o && $past(commit_valid_o)) |->
        (commit_addr_o[ADDR_W-1:OFF_W] == $past(commit_addr_o[ADDR_W-1:OFF_W])));

    // R5
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid_o && $past(commit_valid_o)) |->
        (commit_addr_o[OFF_W-1:0] > $past(commit_addr_o[OFF_W-1:0])));
endmodule

bind pwc_nv_commit_ctrl pwc_nv_commit_chk #(
    .CYCLE_CLKS (CYCLE_CLKS),
    .ADDR_W     (pwc_pkg::PW_ADDR_W),
    .OFF_W      (pwc_pkg::PW_OFF_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stop_i         (stop_i),
    .busy_o         (busy_o),
    .commit_valid_o (commit_valid_o),
    .commit_addr_o  (commit_addr_o)
);

// File: tb/pwc_nv_commit_ctrl_bench.sv
module pwc_nv_commit_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 8;
    localparam int BUSY_EXP   = CYC + 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0, wr_stb_i = 1'b0, vol_only_i = 1'b0;
    logic [10:0] wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic        busy_o, commit_valid_o;
    logic [10:0] commit_addr_o;
    logic [7:0]  commit_data_o;

    int checks = 0, fails = 0;
    int log_n = 0, bsy_cnt = 0;
    bit finished = 1'b0;
    logic [10:0] log_a [32];
    logic [7:0]  log_d [32];
    logic [7:0]  exp_d [16];
    bit          exp_m [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwc_nv_commit_ctrl #(.CYCLE_CLKS(CYC)) u_pwc_nv_commit_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .wr_stb_i(wr_stb_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .vol_only_i(vol_only_i), .busy_o(busy_o), .commit_valid_o(commit_valid_o),
        .commit_addr_o(commit_addr_o), .commit_data_o(commit_data_o)
    );

    always @(negedge clk) begin
        if (busy_o) bsy_cnt++;
        if (commit_valid_o) begin
            if (log_n < 32) begin
                log_a[log_n] = commit_addr_o;
                log_d[log_n] = commit_data_o;
            end
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic op(input bit s, input bit p, input bit w,
                      input logic [10:0] a, input logic [7:0] dat);
        @(negedge clk);
        start_i = s; stop_i = p; wr_stb_i = w; wr_addr_i = a; wr_data_i = dat;
        @(negedge clk);
        start_i = 0; stop_i = 0; wr_stb_i = 0;
    endtask

    task automatic clear_logs();
        @(posedge clk);
        log_n = 0; bsy_cnt = 0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy_o && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    function automatic bit is_vol(input int a, input bit vo);
        return (a == 2046) || (a == 2047 && vo);
    endfunction

    // R2 R3 R4 R5 R6: one sequence of len bytes from page/off0
    task automatic run_seq(input int page, input int off0, input int len, input bit vo);
        int n_exp = 0, k = 0;
        for (int o = 0; o < 16; o++) begin exp_m[o] = 0; exp_d[o] = 0; end
        vol_only_i = vo;
        clear_logs();
        op(1, 0, 0, '0, '0);
        for (int i = 0; i < len; i++) begin
            int o = (off0 + i) % 16;
            int a = page * 16 + o;
            logic [7:0] dv = 8'((page * 7 + off0 * 13 + len * 5 + i * 31) & 255);
            op(0, 0, 1, 11'(page * 16 + off0), dv);
            if (!is_vol(a, vo)) begin exp_m[o] = 1; exp_d[o] = dv; end
        end
        op(0, 1, 0, '0, '0);
        wait_idle();
        for (int o = 0; o < 16; o++) if (exp_m[o]) n_exp++;
        chk(log_n == n_exp, "R5", "commit count", log_n, n_exp);
        chk(bsy_cnt == (n_exp > 0 ? BUSY_EXP : 0), n_exp > 0 ? "R4" : "R6",
            "busy cycles", bsy_cnt, n_exp > 0 ? BUSY_EXP : 0);
        for (int o = 0; o < 16; o++) begin
            if (exp_m[o] && k < log_n && k < 32) begin
                chk(log_a[k] == 11'(page * 16 + o), "R2", "commit addr",
                    int'(log_a[k]), page * 16 + o);
                chk(log_d[k] == exp_d[o], "R3", "commit data",
                    int'(log_d[k]), int'(exp_d[o]));
                k++;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0, "R1", "busy after reset", busy_o, 0);
        chk(commit_valid_o == 0, "R1", "commit after reset", commit_valid_o, 0);

        // near-exhaustive sweep over start offset and length, three pages
        for (int pi = 0; pi < 3; pi++) begin
            int page = (pi == 0) ? 0 : (pi == 1) ? 37 : 127;
            for (int off0 = 0; off0 < 16; off0++) begin
                for (int len = 1; len <= 18; len++) begin
                    run_seq(page, off0, len, (pi == 2) ? bit'(off0 & 1) : 1'b0);
                end
            end
        end

        // R6: only volatile bytes, top address volatile-only
        run_seq(127, 14, 2, 1'b1);
        chk(log_n == 0, "R6", "volatile-only commits", log_n, 0);

        // R7: start before stop discards the buffer
        clear_logs();
        op(1, 0, 0, '0, '0);
        op(0, 0, 1, 11'h120, 8'h11);
        op(0, 0, 1, 11'h120, 8'h22);
        op(1, 0, 0, '0, '0);
        op(0, 1, 0, '0, '0);
        wait_idle();
        chk(bsy_cnt == 0, "R7", "busy after discard", bsy_cnt, 0);
        chk(log_n == 0, "R7", "commits after discard", log_n, 0);

        // R8: bus activity while busy is ignored
        vol_only_i = 1'b0;
        clear_logs();
        op(1, 0, 0, '0, '0);
        op(0, 0, 1, 11'h030, 8'hA1);
        op(0, 0, 1, 11'h030, 8'hA2);
        op(0, 1, 0, '0, '0);
        op(0, 0, 1, 11'h050, 8'hEE);
        op(1, 0, 0, '0, '0);
        op(0, 0, 1, 11'h052, 8'hEF);
        op(0, 1, 0, '0, '0);
        wait_idle();
        chk(log_n == 2, "R8", "commits with busy traffic", log_n, 2);
        chk(log_a[0] == 11'h030 && log_d[0] == 8'hA1, "R8", "first commit",
            int'(log_d[0]), 'hA1);
        chk(log_a[1] == 11'h031 && log_d[1] == 8'hA2, "R8", "second commit",
            int'(log_d[1]), 'hA2);
        chk(bsy_cnt == BUSY_EXP, "R8", "busy cycles with traffic", bsy_cnt, BUSY_EXP);

        // R9 (and R8 leak check): bare stop launches nothing
        clear_logs();
        op(0, 1, 0, '0, '0);
        wait_idle();
        chk(bsy_cnt == 0, "R9", "busy after bare stop", bsy_cnt, 0);
        chk(log_n == 0, "R9", "commits after bare stop", log_n, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule